// File: doc/BRIEF.md
# Palette DAC Host Register File

This block is the host-facing register file of a VGA-style palette converter. A byte-wide port with four decoded addresses gives the host a pixel read mask, a read index, a write index and a colour data window. Behind the data window sits a lookup table of 2**IW entries. Each entry holds a red, a green and a blue channel, and the table is moved one byte per access. After an index is loaded, three data accesses transfer red, then green, then blue. The index then advances by one, so a whole palette can be streamed without reloading it.

A second layer is reached through the mask address. When the host reads the mask port four times in a row, the fourth read returns a fixed identification byte. The access after that reads or writes a hidden command register. Any other access breaks the run and restores plain mask behaviour. Bit 1 of the command register picks the channel precision. With the bit cleared, colour bytes are stored with only their low six bits and read back with bits 7:6 as zero. With the bit set, all eight bits are stored.

Each host strobe lasts a single cycle and is always accepted. There is no ready signal and no back-pressure: the host may issue one access per cycle. Read data is returned one cycle after a read strobe, flagged by `host_rvalid`.

Top module: `palette_dac_regs`

## Requirements
- R1: Address decoding uses `host_addr`: 6 is the mask port, 7 the read index, 8 the write index and 9 colour data. Any other address has no effect on the block and reads 0x00. Read data and `host_rvalid` appear in the cycle after the read strobe, and `host_rvalid` stays low after a write.
- R2: After the write index is loaded, three data writes supply red, green and blue. The entry is written to the table only when its blue byte arrives. Reloading the index part-way through leaves the entry unchanged.
- R3: Writing the read index copies the addressed entry into a read buffer. The next three data reads return its red, green and blue bytes from that buffer.
- R4: Four consecutive mask-port reads behave as follows: the first three return the mask, and the fourth returns the CHIP_ID parameter. The next mask-port access then reads or writes the command register, and after it the read run starts again from zero.
- R5: Any access other than a mask-port read resets the mask-read run. This includes either index port, the data port and unused addresses. After such an access, a mask write updates the mask.
- R6: The mask resets to 0xFF and the command register resets to 0x00. A mask write outside the armed state changes the mask and leaves the command register unchanged. A write in the armed state leaves the mask unchanged.
- R7: With command bit 1 cleared, stored colour bytes keep bits 5:0 and read back with bits 7:6 as zero. With bit 1 set, all eight bits are kept.
- R8: Both the write index and the read index advance by one after the blue byte, wrapping from 2**IW-1 to 0.
- R9: The identification byte is read-only. A write in the armed state goes to the command register, and the next read run still returns CHIP_ID.
- R10: A read of the read-index port returns the current read index, and a read of the write-index port returns the current write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Single-cycle access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Port address (6 mask, 7 read index, 8 write index, 9 data) |
| host_wdata | input | DW | Write byte |
| host_rdata | output | DW | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
A fault in the arming counter shows at the next mask read: either the identification byte appears one read early or late, or the command value leaks out where the mask was expected. A wrong channel phase or index shows as swapped or shifted bytes in the very next read-back of a streamed entry. A fault in the width mode shows as non-zero bits 7:6 on the first data read after a narrow-mode write. Every such fault is therefore visible within one streamed entry, or within one five-read unlock run.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] PORT_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] PORT_RIDX = 4'd7;
  localparam logic [ADDR_W-1:0] PORT_WIDX = 4'd8;
  localparam logic [ADDR_W-1:0] PORT_DATA = 4'd9;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  function automatic chan_e next_chan(input chan_e c);
    case (c)
      CH_RED:   return CH_GREEN;
      CH_GREEN: return CH_BLUE;
      default:  return CH_RED;
    endcase
  endfunction
endpackage

// File: rtl/pdac_mask_unlock.sv
module pdac_mask_unlock #(
  parameter int DW = 8,
  parameter int ARM_READS = 4,
  parameter logic [DW-1:0] CHIP_ID = 8'h5A,
  parameter int MODE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_acc,
  input  logic          mask_rd,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] port_rdata,
  output logic          eight_bit
);
  localparam int CNT_W = $clog2(ARM_READS + 1);
  localparam logic [CNT_W-1:0] ARMED_AT = CNT_W'(ARM_READS);
  localparam logic [CNT_W-1:0] ID_AT    = CNT_W'(ARM_READS - 1);

  logic [CNT_W-1:0] run_q;
  logic [DW-1:0]    mask_q;
  logic [DW-1:0]    cmd_q;
  logic             armed;

  assign armed     = (run_q == ARMED_AT);
  assign eight_bit = cmd_q[MODE_BIT];

  always_comb begin
    if (armed)                port_rdata = cmd_q;
    else if (run_q == ID_AT)  port_rdata = CHIP_ID;
    else                      port_rdata = mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      mask_q <= '1;
      cmd_q  <= '0;
    end else begin
      if (any_acc) run_q <= (mask_rd && !armed) ? run_q + 1'b1 : '0;
      if (mask_wr && !armed) mask_q <= wdata;
      if (mask_wr && armed)  cmd_q  <= wdata;
    end
  end

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= ARMED_AT);

  assert_run_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !mask_rd) |=> (run_q == '0));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_wr && armed) |=> $stable(cmd_q));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && armed) |=> $stable(mask_q));
endmodule

// File: rtl/pdac_wr_path.sv
module pdac_wr_path
  import pdac_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_wr,
  input  logic            data_wr,
  input  logic [DW-1:0]   wdata,
  input  logic            eight_bit,
  output logic [IW-1:0]   widx_q,
  output logic            commit_en,
  output logic [IW-1:0]   commit_addr,
  output logic [3*DW-1:0] commit_data
);
  localparam logic [DW-1:0] NARROW_MASK = {2'b00, {(DW-2){1'b1}}};

  chan_e         phase_q;
  logic [DW-1:0] red_q, grn_q, chan_val;

  assign chan_val    = eight_bit ? wdata : (wdata & NARROW_MASK);
  assign commit_en   = data_wr && (phase_q == CH_BLUE);
  assign commit_addr = widx_q;
  assign commit_data = {red_q, grn_q, chan_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx_q  <= '0;
      phase_q <= CH_RED;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (idx_wr) begin
      widx_q  <= wdata[IW-1:0];
      phase_q <= CH_RED;
    end else if (data_wr) begin
      phase_q <= next_chan(phase_q);
      if (phase_q == CH_RED)   red_q <= chan_val;
      if (phase_q == CH_GREEN) grn_q <= chan_val;
      if (phase_q == CH_BLUE)  widx_q <= widx_q + 1'b1;
    end
  end

  assert_wr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  assert_wr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_wr && phase_q == CH_BLUE) |=> (widx_q == IW'($past(widx_q) + 1'b1)));
endmodule

// File: rtl/pdac_rd_path.sv
module pdac_rd_path
  import pdac_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_wr,
  input  logic            data_rd,
  input  logic [DW-1:0]   wdata,
  output logic [IW-1:0]   ridx_q,
  output logic [IW-1:0]   fetch_addr,
  input  logic [3*DW-1:0] fetch_data,
  output logic [DW-1:0]   port_rdata
);
  chan_e           phase_q;
  logic [3*DW-1:0] buf_q;

  assign fetch_addr = idx_wr ? wdata[IW-1:0] : ridx_q + 1'b1;

  always_comb begin
    case (phase_q)
      CH_RED:   port_rdata = buf_q[3*DW-1:2*DW];
      CH_GREEN: port_rdata = buf_q[2*DW-1:DW];
      default:  port_rdata = buf_q[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ridx_q  <= '0;
      phase_q <= CH_RED;
      buf_q   <= '0;
    end else if (idx_wr) begin
      ridx_q  <= wdata[IW-1:0];
      phase_q <= CH_RED;
      buf_q   <= fetch_data;
    end else if (data_rd) begin
      phase_q <= next_chan(phase_q);
      if (phase_q == CH_BLUE) begin
        ridx_q <= ridx_q + 1'b1;
        buf_q  <= fetch_data;
      end
    end
  end

  assert_rd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (ridx_q == $past(wdata[IW-1:0])) && (phase_q == CH_RED));

  assert_rd_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !idx_wr && phase_q == CH_BLUE) |=> (ridx_q == IW'($past(ridx_q) + 1'b1)));
endmodule

// File: rtl/pdac_lut_mem.sv
module pdac_lut_mem #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [3*DW-1:0] wdata,
  input  logic [IW-1:0]   raddr,
  output logic [3*DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [3*DW-1:0] mem_q [DEPTH];

  assign rdata = mem_q[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/palette_dac_regs.sv
module palette_dac_regs
  import pdac_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [DW-1:0] CHIP_ID = 8'h5A,
  parameter int ARM_READS = 4,
  parameter int MODE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid
);
  logic is_rd, is_wr;
  logic mask_rd, mask_wr, ridx_wr, widx_wr, data_rd, data_wr;

  assign is_rd   = host_valid && !host_write;
  assign is_wr   = host_valid &&  host_write;
  assign mask_rd = is_rd && (host_addr == PORT_MASK);
  assign mask_wr = is_wr && (host_addr == PORT_MASK);
  assign ridx_wr = is_wr && (host_addr == PORT_RIDX);
  assign widx_wr = is_wr && (host_addr == PORT_WIDX);
  assign data_rd = is_rd && (host_addr == PORT_DATA);
  assign data_wr = is_wr && (host_addr == PORT_DATA);

  logic [DW-1:0]   mask_port_rdata, data_port_rdata;
  logic            eight_bit;
  logic [IW-1:0]   widx_q, ridx_q, fetch_addr, commit_addr;
  logic            commit_en;
  logic [3*DW-1:0] commit_data, fetch_data;

  pdac_mask_unlock #(
    .DW(DW), .ARM_READS(ARM_READS), .CHIP_ID(CHIP_ID), .MODE_BIT(MODE_BIT)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .any_acc(host_valid),
    .mask_rd(mask_rd), .mask_wr(mask_wr), .wdata(host_wdata),
    .port_rdata(mask_port_rdata), .eight_bit(eight_bit)
  );

  pdac_wr_path #(.DW(DW), .IW(IW)) u_wr (
    .clk(clk), .rst_n(rst_n), .idx_wr(widx_wr), .data_wr(data_wr),
    .wdata(host_wdata), .eight_bit(eight_bit), .widx_q(widx_q),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  pdac_rd_path #(.DW(DW), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .idx_wr(ridx_wr), .data_rd(data_rd),
    .wdata(host_wdata), .ridx_q(ridx_q), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .port_rdata(data_port_rdata)
  );

  pdac_lut_mem #(.DW(DW), .IW(IW)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(commit_en), .waddr(commit_addr),
    .wdata(commit_data), .raddr(fetch_addr), .rdata(fetch_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= is_rd;
      if (is_rd) begin
        case (host_addr)
          PORT_MASK: host_rdata <= mask_port_rdata;
          PORT_RIDX: host_rdata <= DW'(ridx_q);
          PORT_WIDX: host_rdata <= DW'(widx_q);
          PORT_DATA: host_rdata <= data_port_rdata;
          default:   host_rdata <= '0;
        endcase
      end
    end
  end

  assert_rvalid_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_valid && !host_write));

  assert_write_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_write) |=> !host_rvalid);
endmodule

// File: tb/palette_dac_regs_test.sv
module palette_dac_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 55;

  // vector: {req[25:22], chk[21], wr[20], addr[19:16], wdata[15:8], exp[7:0]}
  function automatic logic [25:0] vrd(input int r, input logic [3:0] a, input logic [7:0] e);
    return {4'(r), 1'b1, 1'b0, a, 8'h00, e};
  endfunction
  function automatic logic [25:0] vwr(input int r, input logic [3:0] a, input logic [7:0] d);
    return {4'(r), 1'b0, 1'b1, a, d, 8'h00};
  endfunction

  localparam logic [25:0] VEC [NV] = '{
    vrd(6, 6, 8'hFF),  // R6 reset mask
    vwr(6, 6, 8'h3C),
    vrd(6, 6, 8'h3C),  // R6 mask write
    vwr(2, 8, 8'h10),
    vwr(2, 9, 8'h11),
    vwr(2, 9, 8'h22),
    vwr(7, 9, 8'hFF),
    vrd(8, 8, 8'h11),  // R8 write index advanced
    vwr(3, 7, 8'h10),
    vrd(3, 9, 8'h11),  // R3 red
    vrd(3, 9, 8'h22),  // R3 green
    vrd(7, 9, 8'h3F),  // R7 narrow blue
    vrd(10, 7, 8'h11), // R10 read index
    vrd(4, 6, 8'h3C),
    vrd(4, 6, 8'h3C),
    vrd(4, 6, 8'h3C),
    vrd(4, 6, 8'h5A),  // R4 id on fourth
    vwr(4, 6, 8'h02),  // command write
    vrd(6, 6, 8'h3C),  // R6 mask untouched by armed write
    vwr(2, 8, 8'h11),
    vwr(7, 9, 8'hC0),
    vwr(7, 9, 8'h81),
    vwr(7, 9, 8'hFF),
    vwr(3, 7, 8'h11),
    vrd(7, 9, 8'hC0),  // R7 wide
    vrd(7, 9, 8'h81),
    vrd(7, 9, 8'hFF),
    vwr(5, 8, 8'h12),
    vrd(4, 6, 8'h3C),
    vrd(4, 6, 8'h3C),
    vrd(4, 6, 8'h3C),
    vrd(9, 6, 8'h5A),  // R9 id still intact
    vrd(4, 6, 8'h02),  // R4 command readback
    vrd(5, 6, 8'h3C),
    vrd(5, 6, 8'h3C),
    vrd(10, 7, 8'h12), // R10 + R5 break run
    vrd(5, 6, 8'h3C),
    vrd(5, 6, 8'h3C),
    vrd(5, 6, 8'h3C),  // R5 third after break still mask
    vrd(4, 6, 8'h5A),
    vrd(4, 6, 8'h02),
    vrd(5, 6, 8'h3C),
    vrd(5, 6, 8'h3C),
    vwr(5, 6, 8'h55),  // mask write mid-run
    vrd(5, 6, 8'h55),  // R5
    vrd(10, 8, 8'h12), // R10 write index
    vrd(1, 3, 8'h00),  // R1 unused address
    vrd(5, 6, 8'h55),
    vrd(5, 6, 8'h55),
    vrd(3, 9, 8'h00),  // data read breaks run
    vrd(5, 6, 8'h55),
    vrd(5, 6, 8'h55),
    vrd(5, 6, 8'h55),  // R5 data access cleared run
    vrd(4, 6, 8'h5A),
    vwr(5, 8, 8'h00)
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_write = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  palette_dac_regs uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic rv);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
    rd = host_rdata; rv = host_rvalid;
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] r; logic v;
    acc(1'b1, a, d, r, v);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] r; logic v;
    acc(1'b0, a, 8'h00, r, v);
    check(req, r, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the read return
    check("R1 rvalid at reset", {7'd0, host_rvalid}, 8'h00);
    check("R1 rdata at reset", host_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][20], VEC[i][19:16], VEC[i][15:8], r, v);
      if (VEC[i][21]) check($sformatf("R%0d vec %0d", VEC[i][25:22], i), r, VEC[i][7:0]);
    end

    // R1: read flag after write and after read
    acc(1'b1, 4'd3, 8'h77, r, v);
    check("R1 rvalid after write", {7'd0, v}, 8'h00);
    acc(1'b0, 4'd6, 8'h00, r, v);
    check("R1 rvalid after read", {7'd0, v}, 8'h01);
    check("R1 write to unused address ignored", r, 8'h55);

    // R8: wrap of both indices (wide mode active)
    wr_b(4'd8, 8'hFF);
    wr_b(4'd9, 8'h01); wr_b(4'd9, 8'h02); wr_b(4'd9, 8'h03);
    wr_b(4'd9, 8'h04); wr_b(4'd9, 8'h05); wr_b(4'd9, 8'h06);
    rd_chk("R8 write index wrapped", 4'd8, 8'h01);
    wr_b(4'd7, 8'hFF);
    rd_chk("R8 entry FF red", 4'd9, 8'h01);
    rd_chk("R8 entry FF green", 4'd9, 8'h02);
    rd_chk("R8 entry FF blue", 4'd9, 8'h03);
    rd_chk("R8 entry 00 red", 4'd9, 8'h04);
    rd_chk("R8 entry 00 green", 4'd9, 8'h05);
    rd_chk("R8 entry 00 blue", 4'd9, 8'h06);
    rd_chk("R8 read index wrapped", 4'd7, 8'h01);

    // R2: partial write is dropped
    wr_b(4'd8, 8'h20);
    wr_b(4'd9, 8'hAA); wr_b(4'd9, 8'hBB);
    wr_b(4'd8, 8'h21);
    wr_b(4'd7, 8'h20);
    rd_chk("R2 partial red", 4'd9, 8'h00);
    rd_chk("R2 partial green", 4'd9, 8'h00);
    rd_chk("R2 partial blue", 4'd9, 8'h00);

    // R9: armed write lands in command register, ID unchanged
    wr_b(4'd8, 8'h00);
    rd_chk("R4 r1", 4'd6, 8'h55); rd_chk("R4 r2", 4'd6, 8'h55); rd_chk("R4 r3", 4'd6, 8'h55);
    rd_chk("R9 id", 4'd6, 8'h5A);
    wr_b(4'd6, 8'h00);
    rd_chk("R6 mask after armed write", 4'd6, 8'h55);
    wr_b(4'd8, 8'h00);
    // R7: narrow mode after clearing bit 1
    wr_b(4'd8, 8'h30);
    wr_b(4'd9, 8'hFF); wr_b(4'd9, 8'h80); wr_b(4'd9, 8'h7F);
    wr_b(4'd7, 8'h30);
    rd_chk("R7 narrow red", 4'd9, 8'h3F);
    rd_chk("R7 narrow green", 4'd9, 8'h00);
    rd_chk("R7 narrow blue", 4'd9, 8'h3F);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule